// File: doc/BRIEF.md
# Flash Command Interface Controller

This block stands in for a 32-bit-wide flash array made from four byte-wide devices placed side by side. A host reaches it through a plain synchronous memory port: one word address, a write strobe, a read strobe, write data and read data. Every write goes to a command decoder. That decoder steers one shared state machine through four read views: stored array contents, identifier codes, the ready status, and the status shown after an erase or program operation.

A command is a single byte value repeated across all lanes. Erasing a block takes two writes: a setup write, then a confirm write aimed at the first word of the block. Programming also takes two writes: a setup write, then a data write that clears bits in the addressed word. The array is an on-chip RAM whose depth, block size and power-up byte are parameters. An erase clears one word per clock, and the controller reports busy until the block is done. Reads have a fixed latency of two clocks. A read strobe and a write strobe must not be raised in the same cycle.

Top module: `flash_cmd_ctrl`

## Requirements
- R1: After reset the controller is in read-array mode with no pending setup command, and a reset clears any earlier mode or pending setup.
- R2: In read-array mode, a read returns the stored word on `rd_data` two clocks after the cycle in which `rd_en` is sampled.
- R3: Writing 0x20202020 and then 0xD0D0D0D0 to a word address whose low `BLK_LOG2` bits are zero sets every word of that block to 0xFFFFFFFF, one word per clock. Words outside that block keep their values.
- R4: An erase confirm (0xD0D0D0D0) starts no erase when the last setup command was not erase setup, or when its address is not aligned to a block.
- R5: Program setup 0x40404040 arms programming. The next accepted write stores (old word AND write data) at its address, clears the pending setup and leaves the controller in status mode.
- R6: A write is also taken as program setup when each byte lane holds either 0x40 or 0xFF and at least one lane holds 0x40, for example 0xFFFF4040 or 0x40FFFFFF.
- R7: Writing 0xFFFFFFFF returns the controller to read-array mode.
- R8: Writing 0x90909090 enters identifier mode. A read at word address 0 then returns 0x89898989, a read at word address 4 returns 0xA0A0A0A0, and a read at any other address returns 0x00000000.
- R9: Writing 0x70707070 enters status mode. In any mode other than read-array and identifier, a read returns 0x80808080 while idle (bit 7 of each lane set means ready).
- R10: While an erase, or the one-cycle program update, is in progress, status reads return 0x00000000 and every write is ignored. Status reads return 0x80808080 again once the operation finishes.
- R11: A write value that matches no command, made while no program setup is pending, changes neither the mode nor the array.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all logic is rising-edge |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | ADDR_W | Word address for reads and writes |
| wr_en | input | 1 | Write strobe (command or program data) |
| wr_data | input | 8*LANES | Write data, one byte per lane |
| rd_en | input | 1 | Read strobe |
| rd_data | output | 8*LANES | Registered read data, valid two clocks after `rd_en` |

## Verification
The bench builds the controller with a 64-word array, 16-word blocks and a power-up byte of 0x5A. With these values an erase finishes in 16 clocks, so a test can watch the busy window and its end. Both neighbouring blocks lie inside the array, which lets the test show that an erase stops exactly at block edges. The non-erased power-up pattern also makes it visible which words an erase or a program actually touched.

// File: rtl/flash_pkg.sv
package flash_pkg;

  typedef enum logic [1:0] {
    MODE_ARRAY  = 2'd0,
    MODE_IDENT  = 2'd1,
    MODE_STATUS = 2'd2
  } mode_e;

  typedef enum logic [1:0] {
    PEND_NONE  = 2'd0,
    PEND_ERASE = 2'd1,
    PEND_PROG  = 2'd2
  } pend_e;

  typedef enum logic [2:0] {
    CMD_NONE        = 3'd0,
    CMD_READ_ARRAY  = 3'd1,
    CMD_IDENT       = 3'd2,
    CMD_STATUS      = 3'd3,
    CMD_ERASE_SETUP = 3'd4,
    CMD_ERASE_GO    = 3'd5,
    CMD_PROG_SETUP  = 3'd6
  } cmd_e;

  localparam logic [7:0] OP_READ_ARRAY  = 8'hFF;
  localparam logic [7:0] OP_IDENT       = 8'h90;
  localparam logic [7:0] OP_STATUS      = 8'h70;
  localparam logic [7:0] OP_ERASE_SETUP = 8'h20;
  localparam logic [7:0] OP_ERASE_GO    = 8'hD0;
  localparam logic [7:0] OP_PROG_SETUP  = 8'h40;

  localparam logic [7:0] CODE_MAKER  = 8'h89;
  localparam logic [7:0] CODE_DEVICE = 8'hA0;
  localparam int unsigned ID_MAKER_WADDR  = 0;
  localparam int unsigned ID_DEVICE_WADDR = 4;

  localparam logic [7:0] STAT_READY = 8'h80;
  localparam logic [7:0] STAT_BUSY  = 8'h00;

endpackage

// File: rtl/flash_cmd_decode.sv
module flash_cmd_decode
  import flash_pkg::*;
#(
  parameter int LANES = 4,
  localparam int DW = 8 * LANES
) (
  input  logic [DW-1:0] wdata,
  output cmd_e          cmd
);

  logic [LANES-1:0] ln_ff, ln_90, ln_70, ln_20, ln_d0, ln_40;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [7:0] b;
    assign b        = wdata[8*g +: 8];
    assign ln_ff[g] = (b == OP_READ_ARRAY);
    assign ln_90[g] = (b == OP_IDENT);
    assign ln_70[g] = (b == OP_STATUS);
    assign ln_20[g] = (b == OP_ERASE_SETUP);
    assign ln_d0[g] = (b == OP_ERASE_GO);
    assign ln_40[g] = (b == OP_PROG_SETUP);
  end

  always_comb begin
    cmd = CMD_NONE;
    if (&ln_ff)                          cmd = CMD_READ_ARRAY;
    else if (&ln_90)                     cmd = CMD_IDENT;
    else if (&ln_70)                     cmd = CMD_STATUS;
    else if (&ln_20)                     cmd = CMD_ERASE_SETUP;
    else if (&ln_d0)                     cmd = CMD_ERASE_GO;
    else if ((&(ln_40 | ln_ff)) && (|ln_40)) cmd = CMD_PROG_SETUP;
  end

endmodule

// File: rtl/flash_array.sv
module flash_array #(
  parameter int         AW        = 10,
  parameter int         DW        = 32,
  parameter logic [7:0] INIT_BYTE = 8'hFF,
  localparam int        DEPTH     = 1 << AW
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);

  logic [DW-1:0] mem [DEPTH];

  initial begin
    for (int i = 0; i < DEPTH; i++) mem[i] = {(DW/8){INIT_BYTE}};
  end

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (re) rdata <= mem[raddr];
  end

endmodule

// File: rtl/flash_erase_seq.sv
module flash_erase_seq #(
  parameter int AW       = 10,
  parameter int BLK_LOG2 = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic [AW-1:0] base,
  output logic          busy,
  output logic          we,
  output logic [AW-1:0] waddr
);

  logic [BLK_LOG2-1:0] idx;
  logic [AW-1:0]       base_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy   <= 1'b0;
      idx    <= '0;
      base_q <= '0;
    end else if (start && !busy) begin
      busy   <= 1'b1;
      idx    <= '0;
      base_q <= base;
    end else if (busy) begin
      idx <= idx + 1'b1;
      if (idx == {BLK_LOG2{1'b1}}) busy <= 1'b0;
    end
  end

  assign we    = busy;
  assign waddr = base_q | AW'(idx);

endmodule

// File: rtl/flash_read_fmt.sv
module flash_read_fmt
  import flash_pkg::*;
#(
  parameter int  AW    = 10,
  parameter int  LANES = 4,
  localparam int DW    = 8 * LANES
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          rd_en,
  input  logic [AW-1:0] addr,
  input  mode_e         mode,
  input  logic          busy,
  input  logic [DW-1:0] memq,
  output logic [DW-1:0] rdata
);

  localparam logic [AW-1:0] MAKER_A  = AW'(ID_MAKER_WADDR);
  localparam logic [AW-1:0] DEVICE_A = AW'(ID_DEVICE_WADDR);

  logic       s1_vld;
  mode_e      s1_mode;
  logic       s1_busy;
  logic [1:0] s1_id;

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_vld  <= 1'b0;
      s1_mode <= MODE_ARRAY;
      s1_busy <= 1'b0;
      s1_id   <= 2'd0;
    end else begin
      s1_vld <= rd_en;
      if (rd_en) begin
        s1_mode <= mode;
        s1_busy <= busy;
        s1_id   <= (addr == MAKER_A)  ? 2'd1 :
                   (addr == DEVICE_A) ? 2'd2 : 2'd0;
      end
    end
  end

  logic [DW-1:0] view;

  always_comb begin
    unique case (s1_mode)
      MODE_ARRAY: view = memq;
      MODE_IDENT: begin
        unique case (s1_id)
          2'd1:    view = {LANES{CODE_MAKER}};
          2'd2:    view = {LANES{CODE_DEVICE}};
          default: view = '0;
        endcase
      end
      default: view = s1_busy ? {LANES{STAT_BUSY}} : {LANES{STAT_READY}};
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)         rdata <= '0;
    else if (s1_vld) rdata <= view;
  end

endmodule

// File: rtl/flash_cmd_ctrl.sv
module flash_cmd_ctrl
  import flash_pkg::*;
#(
  parameter int         ADDR_W    = 10,
  parameter int         BLK_LOG2  = 8,
  parameter int         LANES     = 4,
  parameter logic [7:0] INIT_BYTE = 8'hFF,
  localparam int        DATA_W    = 8 * LANES
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_en,
  output logic [DATA_W-1:0] rd_data
);

  mode_e mode_q;
  pend_e pend_q;
  cmd_e  cmd;

  logic              prog_busy_q;
  logic [ADDR_W-1:0] prog_addr_q;
  logic [DATA_W-1:0] prog_data_q;

  logic              er_busy, er_we;
  logic [ADDR_W-1:0] er_waddr;

  logic              busy, accept, prog_take, erase_start, aligned;
  logic [DATA_W-1:0] memq;

  logic              mem_we;
  logic [ADDR_W-1:0] mem_waddr;
  logic [DATA_W-1:0] mem_wdata;

  flash_cmd_decode #(.LANES(LANES)) u_dec (
    .wdata (wr_data),
    .cmd   (cmd)
  );

  assign busy        = er_busy | prog_busy_q;
  assign accept      = wr_en & ~busy;
  assign prog_take   = accept & (pend_q == PEND_PROG);
  assign aligned     = (addr[BLK_LOG2-1:0] == '0);
  assign erase_start = accept & (pend_q == PEND_ERASE) &
                       (cmd == CMD_ERASE_GO) & aligned;

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q      <= MODE_ARRAY;
      pend_q      <= PEND_NONE;
      prog_busy_q <= 1'b0;
      prog_addr_q <= '0;
      prog_data_q <= '0;
    end else begin
      prog_busy_q <= 1'b0;
      if (prog_take) begin
        prog_busy_q <= 1'b1;
        prog_addr_q <= addr;
        prog_data_q <= wr_data;
        pend_q      <= PEND_NONE;
        mode_q      <= MODE_STATUS;
      end else if (accept) begin
        unique case (cmd)
          CMD_READ_ARRAY:  mode_q <= MODE_ARRAY;
          CMD_IDENT:       mode_q <= MODE_IDENT;
          CMD_STATUS:      mode_q <= MODE_STATUS;
          CMD_ERASE_SETUP: pend_q <= PEND_ERASE;
          CMD_PROG_SETUP:  pend_q <= PEND_PROG;
          CMD_ERASE_GO: begin
            if (erase_start) begin
              pend_q <= PEND_NONE;
              mode_q <= MODE_STATUS;
            end
          end
          default: ;
        endcase
      end
    end
  end

  flash_erase_seq #(.AW(ADDR_W), .BLK_LOG2(BLK_LOG2)) u_erase (
    .clk   (clk),
    .rst   (rst),
    .start (erase_start),
    .base  (addr),
    .busy  (er_busy),
    .we    (er_we),
    .waddr (er_waddr)
  );

  assign mem_we    = er_we | prog_busy_q;
  assign mem_waddr = er_we ? er_waddr : prog_addr_q;
  assign mem_wdata = er_we ? {DATA_W{1'b1}} : (memq & prog_data_q);

  flash_array #(.AW(ADDR_W), .DW(DATA_W), .INIT_BYTE(INIT_BYTE)) u_mem (
    .clk   (clk),
    .we    (mem_we),
    .waddr (mem_waddr),
    .wdata (mem_wdata),
    .re    (rd_en | prog_take),
    .raddr (addr),
    .rdata (memq)
  );

  flash_read_fmt #(.AW(ADDR_W), .LANES(LANES)) u_rfmt (
    .clk   (clk),
    .rst   (rst),
    .rd_en (rd_en),
    .addr  (addr),
    .mode  (mode_q),
    .busy  (busy),
    .memq  (memq),
    .rdata (rd_data)
  );

endmodule

// File: rtl/flash_cmd_ctrl_chk.sv
module flash_cmd_ctrl_chk
  import flash_pkg::*;
#(
  parameter int  ADDR_W   = 10,
  parameter int  BLK_LOG2 = 8,
  parameter int  LANES    = 4,
  localparam int DATA_W   = 8 * LANES
) (
  input logic              clk,
  input logic              rst,
  input logic [ADDR_W-1:0] addr,
  input logic              wr_en,
  input logic [DATA_W-1:0] wr_data,
  input mode_e             mode,
  input pend_e             pend,
  input cmd_e              cmd,
  input logic              er_busy,
  input logic              prog_busy
);

  logic bsy;
  assign bsy = er_busy | prog_busy;

  AST_RESET_IDLE: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (mode == MODE_ARRAY && pend == PEND_NONE && !er_busy)); // R1

  AST_ERASE_ALIGNED: assert property (@(posedge clk) disable iff (rst)
    $rose(er_busy) |-> ($past(addr[BLK_LOG2-1:0]) == '0 &&
                        $past(wr_data) == {LANES{OP_ERASE_GO}})); // R3

  AST_UNALIGNED_NO_ERASE: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !bsy && cmd == CMD_ERASE_GO && addr[BLK_LOG2-1:0] != '0)
      |=> !er_busy); // R4

  AST_PROG_COMPLETES: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !bsy && pend == PEND_PROG)
      |=> (prog_busy && pend == PEND_NONE && mode == MODE_STATUS)); // R5

  AST_FF_TO_ARRAY: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !bsy && pend != PEND_PROG && wr_data == {DATA_W{1'b1}})
      |=> mode == MODE_ARRAY); // R7

  AST_BUSY_IGNORES: assert property (@(posedge clk) disable iff (rst)
    (wr_en && bsy) |=> ($stable(mode) && $stable(pend))); // R10

  AST_UNKNOWN_IGNORED: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !bsy && pend != PEND_PROG && cmd == CMD_NONE)
      |=> ($stable(mode) && $stable(pend) && !er_busy)); // R11

endmodule

bind flash_cmd_ctrl flash_cmd_ctrl_chk #(
  .ADDR_W(ADDR_W), .BLK_LOG2(BLK_LOG2), .LANES(LANES)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .addr      (addr),
  .wr_en     (wr_en),
  .wr_data   (wr_data),
  .mode      (mode_q),
  .pend      (pend_q),
  .cmd       (cmd),
  .er_busy   (er_busy),
  .prog_busy (prog_busy_q)
);

// File: tb/test_flash_cmd_ctrl.sv
module test_flash_cmd_ctrl;

  localparam int AW = 6;
  localparam int BL = 4;
  localparam logic [7:0] IB = 8'h5A;
  localparam logic [31:0] PWRUP = {4{IB}};

  localparam logic [1:0] OP_W = 2'd0;
  localparam logic [1:0] OP_R = 2'd1;
  localparam logic [1:0] OP_D = 2'd2;

  // op[45:44] addr[43:36] data[35:4] req[3:0]
  localparam int NV = 38;
  localparam logic [45:0] VEC [NV] = '{
    {OP_R, 8'd3,  PWRUP,        4'd2},   // R2 power-up word
    {OP_W, 8'd0,  32'h90909090, 4'd8},   // R8
    {OP_R, 8'd0,  32'h89898989, 4'd8},   // R8 maker
    {OP_R, 8'd4,  32'hA0A0A0A0, 4'd8},   // R8 device
    {OP_R, 8'd1,  32'h00000000, 4'd8},   // R8 other
    {OP_W, 8'd0,  32'hFFFFFFFF, 4'd7},   // R7
    {OP_R, 8'd5,  PWRUP,        4'd7},   // R7
    {OP_W, 8'd0,  32'h70707070, 4'd9},   // R9
    {OP_R, 8'd9,  32'h80808080, 4'd9},   // R9
    {OP_W, 8'd0,  32'h55555555, 4'd11},  // R11 unknown value
    {OP_R, 8'd3,  32'h80808080, 4'd11},  // R11 still status
    {OP_W, 8'd0,  32'h20202020, 4'd3},   // R3 setup
    {OP_W, 8'd17, 32'hD0D0D0D0, 4'd4},   // R4 unaligned confirm
    {OP_R, 8'd2,  32'h80808080, 4'd4},   // R4 no busy
    {OP_W, 8'd16, 32'hD0D0D0D0, 4'd3},   // R3 confirm block 1
    {OP_D, 8'd24, 32'h0,        4'd3},
    {OP_W, 8'd0,  32'hFFFFFFFF, 4'd7},
    {OP_R, 8'd16, 32'hFFFFFFFF, 4'd3},   // R3
    {OP_R, 8'd31, 32'hFFFFFFFF, 4'd3},   // R3
    {OP_R, 8'd17, 32'hFFFFFFFF, 4'd3},   // R3
    {OP_R, 8'd32, PWRUP,        4'd3},   // R3 next block kept
    {OP_R, 8'd15, PWRUP,        4'd3},   // R3 prior block kept
    {OP_W, 8'd32, 32'hD0D0D0D0, 4'd4},   // R4 confirm with no setup
    {OP_D, 8'd24, 32'h0,        4'd4},
    {OP_R, 8'd32, PWRUP,        4'd4},   // R4 untouched, still array
    {OP_W, 8'd16, 32'h40404040, 4'd5},   // R5 setup
    {OP_W, 8'd16, 32'h0F0F00FF, 4'd5},   // R5 data
    {OP_R, 8'd7,  32'h80808080, 4'd5},   // R5 status mode
    {OP_W, 8'd0,  32'hFFFFFFFF, 4'd7},
    {OP_R, 8'd16, 32'h0F0F00FF, 4'd5},   // R5
    {OP_W, 8'd16, 32'hFFFF4040, 4'd6},   // R6 partial setup
    {OP_W, 8'd16, 32'h3333FFFF, 4'd6},   // R6 AND data
    {OP_W, 8'd0,  32'hFFFFFFFF, 4'd7},
    {OP_R, 8'd16, 32'h030300FF, 4'd6},   // R6
    {OP_W, 8'd20, 32'h40FFFFFF, 4'd6},   // R6 partial setup
    {OP_W, 8'd20, 32'hF0F0F0F0, 4'd6},   // R6
    {OP_W, 8'd0,  32'h12121212, 4'd11},  // R11 (program done: mode status) no-op
    {OP_R, 8'd16, 32'h80808080, 4'd11}   // R11 mode unchanged
  };

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [AW-1:0] addr = '0;
  logic          wr_en = 1'b0;
  logic [31:0]   wr_data = '0;
  logic          rd_en = 1'b0;
  logic [31:0]   rd_data;

  int total = 0;
  int bad = 0;
  int cyc = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  flash_cmd_ctrl #(.ADDR_W(AW), .BLK_LOG2(BL), .LANES(4), .INIT_BYTE(IB)) i_flash_cmd_ctrl (
    .clk(clk), .rst(rst), .addr(addr), .wr_en(wr_en),
    .wr_data(wr_data), .rd_en(rd_en), .rd_data(rd_data)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 20000 && !done) begin
      bad = bad + 1;
      total = total + 1;
      $display("FAIL R1 watchdog actual=%0d expected<%0d", cyc, 20000);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic do_wr(input logic [7:0] a, input logic [31:0] d);
    addr = a[AW-1:0]; wr_data = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
    @(negedge clk);
  endtask

  task automatic do_rd(input logic [7:0] a, input logic [31:0] exp, input int req);
    addr = a[AW-1:0]; rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
    @(negedge clk);
    total = total + 1;
    if (rd_data !== exp) begin
      bad = bad + 1;
      $display("FAIL R%0d addr=%0d actual=%h expected=%h", req, a, rd_data, exp);
    end
  endtask

  task automatic do_reset();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    @(negedge clk);
    do_reset();
    // R1: reset value of the output register
    total = total + 1;
    if (rd_data !== 32'h0) begin
      bad = bad + 1;
      $display("FAIL R1 reset rd_data actual=%h expected=%h", rd_data, 32'h0);
    end
    for (int i = 0; i < NV; i++) begin
      logic [1:0] op;
      logic [7:0] a;
      logic [31:0] d;
      logic [3:0] rq;
      {op, a, d, rq} = VEC[i];
      case (op)
        OP_W: do_wr(a, d);
        OP_R: do_rd(a, d, int'(rq));
        default: repeat (int'(a)) @(negedge clk);
      endcase
    end
    do_wr(8'd0, 32'hFFFFFFFF);
    do_rd(8'd20, 32'hF0F0F0F0, 6);       // R6 AND into erased word

    // R10: busy window during erase of block 3
    do_wr(8'd0, 32'h20202020);
    do_wr(8'd48, 32'hD0D0D0D0);
    do_rd(8'd1, 32'h00000000, 10);       // R10 busy status
    do_wr(8'd0, 32'h90909090);           // R10 ignored while busy
    repeat (20) @(negedge clk);
    do_rd(8'd0, 32'h80808080, 10);       // R10 ready, still status mode
    do_wr(8'd0, 32'hFFFFFFFF);
    do_rd(8'd48, 32'hFFFFFFFF, 10);      // R10 erase finished

    // R1: reset clears identifier mode
    do_wr(8'd0, 32'h90909090);
    do_reset();
    do_rd(8'd0, PWRUP, 1);               // R1 array view after reset
    // R1: reset clears pending program setup
    do_wr(8'd0, 32'h40404040);
    do_reset();
    do_wr(8'd16, 32'h00000000);
    do_rd(8'd16, 32'h030300FF, 1);       // R1 no program took place

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule